// File: doc/BRIEF.md
# Programmable Interval Clock with Watchdog

The block is a real-time clock peripheral driven by a four-class command bus: control commands, sense queries that answer with a skip pulse, input commands that return a data word, and output commands that write a register. Its interval counter is loaded with a negative preset and advances by one on every line-frequency tick while running. When an increment reaches zero, the counter raises an interrupt request and reloads the preset, so it produces periodic interrupts. A separate watchdog counts system-clock cycles (50 ms by default) once armed and reports a timeout. If enabled, that timeout also raises an external interrupt line.

The block also holds the interrupt vector, the memory-increment cell address, a control word and the panel lights, and it returns the panel switch inputs. The memory-increment cycle itself is not performed here. The block only emits a one-cycle request pulse, timed by a selectable tick source, next to the cell address.

Top module: `iclk_top`

## Requirements
- R1: After reset, irq, wdt_irq, skip, minc_req, rd_data, irq_vector, lights, minc_addr and ctrl_word are all zero, the counter is stopped and the interrupt mask is clear.
- R2: Command class is 0 control, 1 sense, 2 input, 3 output, and function codes below are octal. Output 02 loads the preset and the count. Input 02 returns the current count. The count advances by one per tick_line pulse only while running (started by control 00); ticks while stopped are ignored.
- R3: A tick that takes the count to zero sets the pending flag and reloads the count with the preset, so interrupts repeat every preset-magnitude ticks.
- R4: irq equals pending AND mask; control 15 sets the mask and control 16 clears it, and pending survives while masked.
- R5: Control 01 acknowledges (clears pending); control 00 and control 02 also clear pending; control 02 stops the counter.
- R6: skip is a one-cycle pulse in the cycle after a sense command whose condition holds: 00 irq high, 02 irq low, 05 watchdog timed out, 07 watchdog raised its external interrupt.
- R7: While memory increment is enabled (control 00 enables, control 02 disables), minc_req pulses the cycle after a tick of the selected source: control 04 selects tick_line (reset default), control 05 selects tick_ext.
- R8: Control 06 arms the watchdog and clears its flags; exactly WDT_CYCLES clock cycles after the arming edge it times out; control 07 disarms it without a timeout.
- R9: At timeout, if ctrl_word bit 0 is set, wdt_irq goes high and stays high until control 06 or control 17.
- R10: Output 07, 12, 13, 17 write ctrl_word, minc_addr, irq_vector and lights; input 12 and 13 read back the cell address and vector.
- R11: Input 16 returns sw_up, input 17 returns sw_down, and input 11 returns acc_in OR DEV_ID.
- R12: Control 17 returns every register, flag and output to the reset condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_line | input | 1 | Line-frequency tick strobe |
| tick_ext | input | 1 | External clock tick strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_class | input | 2 | 0 control, 1 sense, 2 input, 3 output |
| cmd_func | input | 4 | Function code |
| cmd_data | input | DW | Output-command data |
| acc_in | input | DW | Accumulator value merged by input 11 |
| sw_up | input | DW | Panel switches, up position |
| sw_down | input | DW | Panel switches, momentary down |
| irq | output | 1 | Interval interrupt request |
| irq_vector | output | DW | Interrupt vector register |
| wdt_irq | output | 1 | Watchdog external interrupt |
| skip | output | 1 | Sense result pulse |
| rd_data | output | DW | Last input-command result |
| lights | output | DW | Panel lights register |
| minc_req | output | 1 | Memory-increment request pulse |
| minc_addr | output | DW | Memory-increment cell address |
| ctrl_word | output | DW | Control register |

## Verification
A count that is off by one shows up at the ports as an interrupt that comes one tick early or late in every period. It also shows up as a wrong word on the next input 02, so it is visible within one period. A pending flag that fails to clear or fails to survive masking shows on irq in the cycle after the mask or acknowledge command. A watchdog limit that is off shows on wdt_irq at the exact edge where it should have risen. A lost source select shows on minc_req after the very next tick of either source.

// File: rtl/iclk_pkg.sv
package iclk_pkg;

    typedef enum logic [1:0] {
        CLS_CTL   = 2'd0,
        CLS_SENSE = 2'd1,
        CLS_READ  = 2'd2,
        CLS_WRITE = 2'd3
    } io_class_e;

    // control functions
    localparam logic [3:0] FN_START    = 4'o00;
    localparam logic [3:0] FN_ACK      = 4'o01;
    localparam logic [3:0] FN_STOP     = 4'o02;
    localparam logic [3:0] FN_SEL_LINE = 4'o04;
    localparam logic [3:0] FN_SEL_EXT  = 4'o05;
    localparam logic [3:0] FN_WDT_GO   = 4'o06;
    localparam logic [3:0] FN_WDT_HALT = 4'o07;
    localparam logic [3:0] FN_MASK_SET = 4'o15;
    localparam logic [3:0] FN_MASK_CLR = 4'o16;
    localparam logic [3:0] FN_CLEAR    = 4'o17;
    // sense functions
    localparam logic [3:0] SN_IRQ      = 4'o00;
    localparam logic [3:0] SN_NO_IRQ   = 4'o02;
    localparam logic [3:0] SN_WDT_TO   = 4'o05;
    localparam logic [3:0] SN_WDT_INT  = 4'o07;
    // output functions
    localparam logic [3:0] WR_INTERVAL = 4'o02;
    localparam logic [3:0] WR_CTRL     = 4'o07;
    localparam logic [3:0] WR_CELL     = 4'o12;
    localparam logic [3:0] WR_VEC      = 4'o13;
    localparam logic [3:0] WR_LIGHTS   = 4'o17;
    // input functions
    localparam logic [3:0] RD_INTERVAL = 4'o02;
    localparam logic [3:0] RD_ID       = 4'o11;
    localparam logic [3:0] RD_CELL     = 4'o12;
    localparam logic [3:0] RD_VEC      = 4'o13;
    localparam logic [3:0] RD_UP       = 4'o16;
    localparam logic [3:0] RD_DOWN     = 4'o17;

    typedef struct packed {
        logic load;
        logic start;
        logic stop;
        logic ack;
        logic mask_set;
        logic mask_clr;
        logic clear_all;
        logic sel_line;
        logic sel_ext;
        logic wdt_go;
        logic wdt_halt;
        logic wr_ctrl;
        logic wr_cell;
        logic wr_vec;
        logic wr_lights;
    } ctl_t;

    function automatic logic sense_hit(input logic [3:0] fn, input logic irq,
                                       input logic wdt_to, input logic wdt_int);
        case (fn)
            SN_IRQ:     return irq;
            SN_NO_IRQ:  return !irq;
            SN_WDT_TO:  return wdt_to;
            SN_WDT_INT: return wdt_int;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/iclk_decode.sv
module iclk_decode
    import iclk_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_class,
    input  logic [3:0]  cmd_func,
    output ctl_t        ctl
);
    always_comb begin
        ctl = '0;
        if (cmd_valid) begin
            if (cmd_class == CLS_CTL) begin
                case (cmd_func)
                    FN_START:    ctl.start     = 1'b1;
                    FN_ACK:      ctl.ack       = 1'b1;
                    FN_STOP:     ctl.stop      = 1'b1;
                    FN_SEL_LINE: ctl.sel_line  = 1'b1;
                    FN_SEL_EXT:  ctl.sel_ext   = 1'b1;
                    FN_WDT_GO:   ctl.wdt_go    = 1'b1;
                    FN_WDT_HALT: ctl.wdt_halt  = 1'b1;
                    FN_MASK_SET: ctl.mask_set  = 1'b1;
                    FN_MASK_CLR: ctl.mask_clr  = 1'b1;
                    FN_CLEAR:    ctl.clear_all = 1'b1;
                    default:     ;
                endcase
            end else if (cmd_class == CLS_WRITE) begin
                case (cmd_func)
                    WR_INTERVAL: ctl.load      = 1'b1;
                    WR_CTRL:     ctl.wr_ctrl   = 1'b1;
                    WR_CELL:     ctl.wr_cell   = 1'b1;
                    WR_VEC:      ctl.wr_vec    = 1'b1;
                    WR_LIGHTS:   ctl.wr_lights = 1'b1;
                    default:     ;
                endcase
            end
        end
    end
endmodule

// File: rtl/iclk_interval.sv
module iclk_interval #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          start,
    input  logic          stop,
    input  logic          ack,
    input  logic          clear_all,
    output logic [DW-1:0] count,
    output logic [DW-1:0] preset,
    output logic          pending,
    output logic          ovf
);
    logic [DW-1:0] count_q, preset_q, next_cnt;
    logic          run_q, pend_q;

    assign next_cnt = count_q + 1'b1;
    assign ovf      = run_q && tick && !load && !clear_all && (next_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            count_q  <= '0;
            preset_q <= '0;
            run_q    <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (load) begin
                count_q  <= load_val;
                preset_q <= load_val;
            end else if (run_q && tick) begin
                count_q  <= ovf ? preset_q : next_cnt;
            end
            if (start)      run_q <= 1'b1;
            else if (stop)  run_q <= 1'b0;
            if (ovf)                     pend_q <= 1'b1;
            else if (ack || start || stop) pend_q <= 1'b0;
        end
    end

    assign count   = count_q;
    assign preset  = preset_q;
    assign pending = pend_q;
endmodule

// File: rtl/iclk_watchdog.sv
module iclk_watchdog #(
    parameter int LIMIT = 6_250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic halt,
    input  logic clear_all,
    input  logic int_en,
    output logic running,
    output logic timed_out,
    output logic xint
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q, to_q, xint_q;

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            cnt_q  <= '0;
            run_q  <= 1'b0;
            to_q   <= 1'b0;
            xint_q <= 1'b0;
        end else if (go) begin
            cnt_q  <= '0;
            run_q  <= 1'b1;
            to_q   <= 1'b0;
            xint_q <= 1'b0;
        end else if (halt) begin
            run_q  <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == LAST) begin
                run_q  <= 1'b0;
                to_q   <= 1'b1;
                xint_q <= int_en;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign running   = run_q;
    assign timed_out = to_q;
    assign xint      = xint_q;
endmodule

// File: rtl/iclk_top.sv
module iclk_top
    import iclk_pkg::*;
#(
    parameter int          DW         = 16,
    parameter int          CLK_HZ     = 125_000_000,
    parameter int          WDT_CYCLES = CLK_HZ / 20,
    parameter logic [15:0] DEV_ID     = 16'o20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_line,
    input  logic          tick_ext,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_class,
    input  logic [3:0]    cmd_func,
    input  logic [DW-1:0] cmd_data,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] sw_up,
    input  logic [DW-1:0] sw_down,
    output logic          irq,
    output logic [DW-1:0] irq_vector,
    output logic          wdt_irq,
    output logic          skip,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] lights,
    output logic          minc_req,
    output logic [DW-1:0] minc_addr,
    output logic [DW-1:0] ctrl_word
);
    ctl_t          ctl;
    logic [DW-1:0] count, preset;
    logic          pending, ovf;
    logic          wdt_run, wdt_to, wdt_xint;
    logic          mask_q, minc_en_q, minc_sel_q, minc_req_q, skip_q;
    logic [DW-1:0] vec_q, cell_q, ctrl_q, lights_q, rd_q;
    logic          rd_hit, sense_now;
    logic [DW-1:0] rd_val;

    iclk_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_class (cmd_class),
        .cmd_func  (cmd_func),
        .ctl       (ctl)
    );

    iclk_interval #(.DW(DW)) u_int (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_line),
        .load      (ctl.load),
        .load_val  (cmd_data),
        .start     (ctl.start),
        .stop      (ctl.stop),
        .ack       (ctl.ack),
        .clear_all (ctl.clear_all),
        .count     (count),
        .preset    (preset),
        .pending   (pending),
        .ovf       (ovf)
    );

    iclk_watchdog #(.LIMIT(WDT_CYCLES)) u_wdt (
        .clk       (clk),
        .rst       (rst),
        .go        (ctl.wdt_go),
        .halt      (ctl.wdt_halt),
        .clear_all (ctl.clear_all),
        .int_en    (ctrl_q[0]),
        .running   (wdt_run),
        .timed_out (wdt_to),
        .xint      (wdt_xint)
    );

    assign irq = pending && mask_q;
    assign sense_now = cmd_valid && (cmd_class == CLS_SENSE) &&
                       sense_hit(cmd_func, irq, wdt_to, wdt_xint);

    always_comb begin
        rd_hit = cmd_valid && (cmd_class == CLS_READ);
        rd_val = rd_q;
        case (cmd_func)
            RD_INTERVAL: rd_val = count;
            RD_ID:       rd_val = acc_in | DW'(DEV_ID);
            RD_CELL:     rd_val = cell_q;
            RD_VEC:      rd_val = vec_q;
            RD_UP:       rd_val = sw_up;
            RD_DOWN:     rd_val = sw_down;
            default:     rd_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clear_all) begin
            mask_q     <= 1'b0;
            minc_en_q  <= 1'b0;
            minc_sel_q <= 1'b0;
            minc_req_q <= 1'b0;
            skip_q     <= 1'b0;
            vec_q      <= '0;
            cell_q     <= '0;
            ctrl_q     <= '0;
            lights_q   <= '0;
            rd_q       <= '0;
        end else begin
            if (ctl.mask_set)      mask_q <= 1'b1;
            else if (ctl.mask_clr) mask_q <= 1'b0;
            if (ctl.start)         minc_en_q <= 1'b1;
            else if (ctl.stop)     minc_en_q <= 1'b0;
            if (ctl.sel_ext)       minc_sel_q <= 1'b1;
            else if (ctl.sel_line) minc_sel_q <= 1'b0;
            minc_req_q <= minc_en_q && (minc_sel_q ? tick_ext : tick_line);
            skip_q     <= sense_now;
            if (ctl.wr_ctrl)   ctrl_q   <= cmd_data;
            if (ctl.wr_cell)   cell_q   <= cmd_data;
            if (ctl.wr_vec)    vec_q    <= cmd_data;
            if (ctl.wr_lights) lights_q <= cmd_data;
            if (rd_hit)        rd_q     <= rd_val;
        end
    end

    assign irq_vector = vec_q;
    assign wdt_irq    = wdt_xint;
    assign skip       = skip_q;
    assign rd_data    = rd_q;
    assign lights     = lights_q;
    assign minc_req   = minc_req_q;
    assign minc_addr  = cell_q;
    assign ctrl_word  = ctrl_q;
endmodule

// File: rtl/iclk_chk.sv
module iclk_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [1:0]    cmd_class,
    input logic [3:0]    cmd_func,
    input logic          irq,
    input logic          wdt_irq,
    input logic          skip,
    input logic          minc_req,
    input logic [DW-1:0] irq_vector,
    input logic          mask_q,
    input logic          minc_en_q,
    input logic          ovf,
    input logic [DW-1:0] count,
    input logic [DW-1:0] preset,
    input logic          wdt_run,
    input logic          wdt_to
);
    assert_irq_masked_R4: assert property (@(posedge clk) disable iff (rst)
        !mask_q |-> !irq);

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class == 2'd0 && cmd_func == 4'o01 && !ovf) |=> !irq);

    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (count == $past(preset)));

    assert_skip_source_R6: assert property (@(posedge clk) disable iff (rst)
        skip |-> $past(cmd_valid && cmd_class == 2'd1));

    assert_wdt_from_run_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_to) |-> $past(wdt_run));

    assert_minc_gate_R7: assert property (@(posedge clk) disable iff (rst)
        minc_req |-> $past(minc_en_q));

    assert_clear_all_R12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_class == 2'd0 && cmd_func == 4'o17)
        |=> (!irq && !wdt_irq && irq_vector == '0));
endmodule

bind iclk_top iclk_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_class  (cmd_class),
    .cmd_func   (cmd_func),
    .irq        (irq),
    .wdt_irq    (wdt_irq),
    .skip       (skip),
    .minc_req   (minc_req),
    .irq_vector (irq_vector),
    .mask_q     (mask_q),
    .minc_en_q  (minc_en_q),
    .ovf        (ovf),
    .count      (count),
    .preset     (preset),
    .wdt_run    (wdt_run),
    .wdt_to     (wdt_to)
);

// File: tb/iclk_top_tb_top.sv
module iclk_top_tb_top;
    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_line = 1'b0, tick_ext = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_class = '0;
    logic [3:0]  cmd_func = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] acc_in = 16'h8001;
    logic [15:0] sw_up = 16'h0F0F, sw_down = 16'hF00F;
    logic        irq, wdt_irq, skip, minc_req;
    logic [15:0] irq_vector, rd_data, lights, minc_addr, ctrl_word;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iclk_top #(.WDT_CYCLES(W)) dut_i (
        .clk(clk), .rst(rst), .tick_line(tick_line), .tick_ext(tick_ext),
        .cmd_valid(cmd_valid), .cmd_class(cmd_class), .cmd_func(cmd_func),
        .cmd_data(cmd_data), .acc_in(acc_in), .sw_up(sw_up), .sw_down(sw_down),
        .irq(irq), .irq_vector(irq_vector), .wdt_irq(wdt_irq), .skip(skip),
        .rd_data(rd_data), .lights(lights), .minc_req(minc_req),
        .minc_addr(minc_addr), .ctrl_word(ctrl_word)
    );

    // {class, func, data, check_rd, exp_skip, exp_rd}
    localparam logic [39:0] VECS [12] = '{
        {2'd3, 4'o12, 16'h1234, 1'b0, 1'b0, 16'h0000},
        {2'd2, 4'o12, 16'h0000, 1'b1, 1'b0, 16'h1234},
        {2'd3, 4'o13, 16'h00A5, 1'b0, 1'b0, 16'h0000},
        {2'd2, 4'o13, 16'h0000, 1'b1, 1'b0, 16'h00A5},
        {2'd3, 4'o17, 16'h5A5A, 1'b0, 1'b0, 16'h0000},
        {2'd2, 4'o16, 16'h0000, 1'b1, 1'b0, 16'h0F0F},
        {2'd2, 4'o17, 16'h0000, 1'b1, 1'b0, 16'hF00F},
        {2'd2, 4'o11, 16'h0000, 1'b1, 1'b0, 16'h8011},
        {2'd1, 4'o02, 16'h0000, 1'b0, 1'b1, 16'h0000},
        {2'd1, 4'o00, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {2'd1, 4'o05, 16'h0000, 1'b0, 1'b0, 16'h0000},
        {2'd1, 4'o07, 16'h0000, 1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] c, input logic [3:0] f, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_class = c; cmd_func = f; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic tick(input bit ext);
        @(negedge clk);
        if (ext) tick_ext = 1'b1; else tick_line = 1'b1;
        @(negedge clk);
        tick_ext = 1'b0; tick_line = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 wdt_irq", {15'd0, wdt_irq}, 16'd0);
        chk("R1 skip", {15'd0, skip}, 16'd0);
        chk("R1 minc_req", {15'd0, minc_req}, 16'd0);
        chk("R1 vector", irq_vector, 16'd0);
        chk("R1 lights", lights, 16'd0);
        chk("R1 rd_data", rd_data, 16'd0);

        // R10 R11 R6 register and sense vectors
        foreach (VECS[i]) begin
            cmd(VECS[i][39:38], VECS[i][37:34], VECS[i][33:18]);
            chk("R6 skip vector", {15'd0, skip}, {15'd0, VECS[i][16]});
            if (VECS[i][17]) chk("R10/R11 read vector", rd_data, VECS[i][15:0]);
        end
        chk("R10 irq_vector", irq_vector, 16'h00A5);
        chk("R10 lights", lights, 16'h5A5A);
        chk("R10 minc_addr", minc_addr, 16'h1234);

        // R2 load, stopped ticks ignored, counting
        cmd(2'd3, 4'o02, 16'hFFFD);
        cmd(2'd2, 4'o02, 16'h0);
        chk("R2 preset readback", rd_data, 16'hFFFD);
        tick(0);
        cmd(2'd2, 4'o02, 16'h0);
        chk("R2 stopped ignores tick", rd_data, 16'hFFFD);
        cmd(2'd0, 4'o00, 16'h0);
        tick(0);
        cmd(2'd2, 4'o02, 16'h0);
        chk("R2 count advances", rd_data, 16'hFFFE);

        // R3 R4 overflow and reload
        cmd(2'd0, 4'o15, 16'h0);
        tick(0);
        chk("R3 no early irq", {15'd0, irq}, 16'd0);
        tick(0);
        chk("R3 irq at zero", {15'd0, irq}, 16'd1);
        cmd(2'd2, 4'o02, 16'h0);
        chk("R3 reload preset", rd_data, 16'hFFFD);
        cmd(2'd1, 4'o00, 16'h0);
        chk("R6 sense irq", {15'd0, skip}, 16'd1);
        cmd(2'd1, 4'o02, 16'h0);
        chk("R6 sense no irq", {15'd0, skip}, 16'd0);
        cmd(2'd0, 4'o16, 16'h0);
        chk("R4 mask clear", {15'd0, irq}, 16'd0);
        cmd(2'd0, 4'o15, 16'h0);
        chk("R4 pending kept", {15'd0, irq}, 16'd1);

        // R5 ack, periodic, stop
        cmd(2'd0, 4'o01, 16'h0);
        chk("R5 ack", {15'd0, irq}, 16'd0);
        tick(0); tick(0);
        chk("R3 period not yet", {15'd0, irq}, 16'd0);
        tick(0);
        chk("R3 periodic irq", {15'd0, irq}, 16'd1);
        cmd(2'd0, 4'o02, 16'h0);
        chk("R5 stop clears", {15'd0, irq}, 16'd0);
        tick(0); tick(0); tick(0);
        chk("R5 stopped no irq", {15'd0, irq}, 16'd0);

        // R7 memory increment request
        tick(0);
        chk("R7 disabled", {15'd0, minc_req}, 16'd0);
        cmd(2'd0, 4'o00, 16'h0);
        tick(0);
        chk("R7 line source", {15'd0, minc_req}, 16'd1);
        tick(1);
        chk("R7 ext ignored", {15'd0, minc_req}, 16'd0);
        cmd(2'd0, 4'o05, 16'h0);
        tick(1);
        chk("R7 ext source", {15'd0, minc_req}, 16'd1);
        tick(0);
        chk("R7 line ignored", {15'd0, minc_req}, 16'd0);
        cmd(2'd0, 4'o02, 16'h0);
        tick(1);
        chk("R7 stop disables", {15'd0, minc_req}, 16'd0);

        // R8 R9 watchdog
        cmd(2'd3, 4'o07, 16'h0001);
        chk("R10 ctrl_word", ctrl_word, 16'h0001);
        cmd(2'd0, 4'o06, 16'h0);
        repeat (10) @(negedge clk);
        cmd(2'd0, 4'o07, 16'h0);
        repeat (25) @(negedge clk);
        chk("R8 halted no irq", {15'd0, wdt_irq}, 16'd0);
        cmd(2'd1, 4'o05, 16'h0);
        chk("R8 halted no timeout", {15'd0, skip}, 16'd0);
        cmd(2'd0, 4'o06, 16'h0);
        repeat (W - 1) @(negedge clk);
        chk("R8 one cycle before limit", {15'd0, wdt_irq}, 16'd0);
        @(negedge clk);
        chk("R9 irq at limit", {15'd0, wdt_irq}, 16'd1);
        cmd(2'd1, 4'o05, 16'h0);
        chk("R8 sense timeout", {15'd0, skip}, 16'd1);
        cmd(2'd1, 4'o07, 16'h0);
        chk("R9 sense ext int", {15'd0, skip}, 16'd1);
        cmd(2'd3, 4'o07, 16'h0000);
        cmd(2'd0, 4'o06, 16'h0);
        chk("R9 rearm clears", {15'd0, wdt_irq}, 16'd0);
        repeat (W + 5) @(negedge clk);
        chk("R9 disabled no irq", {15'd0, wdt_irq}, 16'd0);
        cmd(2'd1, 4'o05, 16'h0);
        chk("R8 timeout without int", {15'd0, skip}, 16'd1);
        cmd(2'd1, 4'o07, 16'h0);
        chk("R9 no ext int", {15'd0, skip}, 16'd0);

        // R12 master clear
        cmd(2'd3, 4'o02, 16'hFFFF);
        cmd(2'd0, 4'o00, 16'h0);
        cmd(2'd0, 4'o15, 16'h0);
        tick(0);
        chk("R12 setup irq", {15'd0, irq}, 16'd1);
        cmd(2'd0, 4'o17, 16'h0);
        chk("R12 irq", {15'd0, irq}, 16'd0);
        chk("R12 vector", irq_vector, 16'd0);
        chk("R12 lights", lights, 16'd0);
        chk("R12 minc_addr", minc_addr, 16'd0);
        cmd(2'd2, 4'o02, 16'h0);
        chk("R12 count", rd_data, 16'd0);
        tick(0);
        chk("R12 stopped", {15'd0, minc_req}, 16'd0);

        done = 1'b1;
        finish_run();
    end
endmodule